// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Unit

This block holds the interrupt registers of a serial port controller. Thirteen interrupt sources each have one enable bit in a mask and one sticky bit in a status register. Software never writes the mask directly. One write port sets mask bits, another clears them, and the current mask is visible as a read-only output. The datapath reports events as single-cycle pulses. Each pulse latches into its status bit, and the bit stays set until software writes a one to it.

The receive-trigger source has a second way to fire. The block compares the receive FIFO fill level with a programmable 6-bit threshold. Status bit 0 is set when the fill level first reaches that threshold. A single level interrupt output is asserted whenever any latched status bit is also enabled in the mask.

Top module: `irq_mask_unit`

## Requirements
- R1: When `en_we` is high, every bit that is 1 in `en_wdata` is set in `mask_view` after the clock edge. Bits that are 0 leave their mask bit unchanged. With no write strobe active, the mask holds its value.
- R2: When `dis_we` is high, every bit that is 1 in `dis_wdata` is cleared in `mask_view` after the clock edge. Bits that are 0 leave their mask bit unchanged.
- R3: If both write ports target the same bit in one cycle, that mask bit ends up cleared.
- R4: A 1 on any bit of `evt` sets the matching bit of `status_view` after the clock edge. The bit order is: 0 rx trigger, 1 rx empty, 2 rx full, 3 tx empty, 4 tx full, 5 rx overrun, 6 framing error, 7 parity error, 8 rx timeout, 9 modem status change, 10 tx trigger, 11 tx nearly full, 12 tx overrun. A set status bit stays set after the pulse ends.
- R5: When `stat_we` is high, every bit that is 1 in `stat_wdata` clears the matching status bit. Bits that are 0 leave the status bit unchanged.
- R6: If an event and a clear hit the same status bit in the same cycle, the bit is set after the edge.
- R7: `irq` is high exactly when some bit is set in both `status_view` and `mask_view`. It follows those registers with no further delay.
- R8: Status bit 0 is set on the clock edge at which `rx_fill >= rx_thresh` first becomes true with `rx_thresh` non-zero. A fill level that stays at or above the threshold does not set the bit again after it has been cleared. A threshold of 0 disables this comparison.
- R9: After reset, `mask_view`, `status_view` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_we | input | 1 | Enable-port write strobe |
| en_wdata | input | 13 | Mask bits to set |
| dis_we | input | 1 | Disable-port write strobe |
| dis_wdata | input | 13 | Mask bits to clear |
| stat_we | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 13 | Status bits to clear |
| evt | input | 13 | Event pulses from the datapath |
| rx_fill | input | 7 | Receive FIFO fill level |
| rx_thresh | input | 6 | Receive trigger threshold (0 disables) |
| mask_view | output | 13 | Current mask |
| status_view | output | 13 | Current sticky status |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are collisions within one cycle. One is an event pulse arriving on the same edge as a clear write to that bit. Another is an enable and a disable write hitting the same mask bit together. The vector table drives both collisions in a single vector each, then checks the registers after that edge. The trigger is edge-based, so its check clears status bit 0 while the fill level stays above the threshold. The fill level then rises further, and later falls and rises again. The bench checks that only the second rising crossing sets the bit again.

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int NSRC = 13,
  parameter int THRW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            dis_we,
  input  logic [NSRC-1:0] dis_wdata,
  input  logic            stat_we,
  input  logic [NSRC-1:0] stat_wdata,
  input  logic [NSRC-1:0] evt,
  input  logic [THRW:0]   rx_fill,
  input  logic [THRW-1:0] rx_thresh,
  output logic [NSRC-1:0] mask_view,
  output logic [NSRC-1:0] status_view,
  output logic            irq
);

  logic [NSRC-1:0] mask_q, stat_q;
  logic            trig_q;

  wire             trig_now = (rx_thresh != '0) && (rx_fill >= {1'b0, rx_thresh});
  wire [NSRC-1:0]  trig_vec = {{(NSRC-1){1'b0}}, trig_now & ~trig_q};
  wire [NSRC-1:0]  set_bits = evt | trig_vec;
  wire [NSRC-1:0]  clr_bits = stat_we ? stat_wdata : '0;
  wire [NSRC-1:0]  en_bits  = en_we ? en_wdata : '0;
  wire [NSRC-1:0]  dis_bits = dis_we ? dis_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      trig_q <= 1'b0;
    end else begin
      mask_q <= (mask_q | en_bits) & ~dis_bits;
      stat_q <= (stat_q & ~clr_bits) | set_bits;
      trig_q <= trig_now;
    end
  end

  assign mask_view   = mask_q;
  assign status_view = stat_q;
  assign irq         = |(stat_q & mask_q);

endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk #(
  parameter int NSRC = 13,
  parameter int THRW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_we,
  input logic [NSRC-1:0] en_wdata,
  input logic            dis_we,
  input logic [NSRC-1:0] dis_wdata,
  input logic            stat_we,
  input logic [NSRC-1:0] stat_wdata,
  input logic [NSRC-1:0] evt,
  input logic [THRW:0]   rx_fill,
  input logic [THRW-1:0] rx_thresh,
  input logic [NSRC-1:0] mask_view,
  input logic [NSRC-1:0] status_view,
  input logic            irq
);

  localparam logic [NSRC-1:0] NOT_B0 = ~{{(NSRC-1){1'b0}}, 1'b1};

  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !dis_we) |=> ((mask_view & $past(en_wdata)) == $past(en_wdata))); // R1

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_we && !dis_we) |=> $stable(mask_view)); // R1

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_we |=> ((mask_view & $past(dis_wdata)) == '0)); // R3

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status_view & $past(evt)) == $past(evt))); // R6

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((status_view & $past(stat_wdata & ~evt) & NOT_B0) == '0)); // R5

  AST_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> (((status_view & ~$past(status_view)) & NOT_B0) == '0)); // R4

  AST_TRIG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt[0] && !(rx_thresh != '0 && rx_fill >= {1'b0, rx_thresh}))
      |=> !(status_view[0] && !$past(status_view[0]))); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_view & mask_view) == '0) |-> !irq); // R7

  AST_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_view & mask_view) != '0) |-> irq); // R7

endmodule

bind irq_mask_unit irq_mask_unit_chk #(.NSRC(NSRC), .THRW(THRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
  .dis_we(dis_we), .dis_wdata(dis_wdata), .stat_we(stat_we),
  .stat_wdata(stat_wdata), .evt(evt), .rx_fill(rx_fill),
  .rx_thresh(rx_thresh), .mask_view(mask_view),
  .status_view(status_view), .irq(irq)
);

// File: tb/irq_mask_unit_bench.sv
`timescale 1ns/1ps
module irq_mask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_we = 1'b0, dis_we = 1'b0, stat_we = 1'b0;
  logic [12:0] en_wdata = '0, dis_wdata = '0, stat_wdata = '0, evt = '0;
  logic [6:0]  rx_fill = '0;
  logic [5:0]  rx_thresh = '0;
  logic [12:0] mask_view, status_view;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  irq_mask_unit u_irq_mask_unit (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .dis_we(dis_we), .dis_wdata(dis_wdata), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .evt(evt), .rx_fill(rx_fill),
    .rx_thresh(rx_thresh), .mask_view(mask_view),
    .status_view(status_view), .irq(irq)
  );

  // {en_we, en_d, dis_we, dis_d, stat_we, stat_d, evt, exp_mask, exp_stat, exp_irq}
  localparam int NV = 12;
  localparam logic [81:0] TBL [NV] = '{
    {1'b1,13'h0005, 1'b0,13'h0000, 1'b0,13'h0000, 13'h0000, 13'h0005,13'h0000,1'b0}, // R1
    {1'b0,13'h0000, 1'b0,13'h0000, 1'b0,13'h0000, 13'h0004, 13'h0005,13'h0004,1'b1}, // R4 R7
    {1'b1,13'h1000, 1'b1,13'h1004, 1'b0,13'h0000, 13'h0000, 13'h0001,13'h0004,1'b0}, // R2 R3
    {1'b0,13'h0000, 1'b0,13'h0000, 1'b0,13'h0000, 13'h1001, 13'h0001,13'h1005,1'b1}, // R4
    {1'b0,13'h0000, 1'b0,13'h0000, 1'b1,13'h0001, 13'h0000, 13'h0001,13'h1004,1'b0}, // R5
    {1'b0,13'h0000, 1'b0,13'h0000, 1'b1,13'h1000, 13'h1000, 13'h0001,13'h1004,1'b0}, // R6
    {1'b1,13'h1000, 1'b0,13'h0000, 1'b0,13'h0000, 13'h0000, 13'h1001,13'h1004,1'b1}, // R7
    {1'b0,13'h0000, 1'b0,13'h0000, 1'b1,13'h0000, 13'h0000, 13'h1001,13'h1004,1'b1}, // R5
    {1'b0,13'h0000, 1'b1,13'h0000, 1'b0,13'h0000, 13'h0000, 13'h1001,13'h1004,1'b1}, // R2
    {1'b0,13'h0000, 1'b0,13'h0000, 1'b1,13'h1FFF, 13'h0000, 13'h1001,13'h0000,1'b0}, // R5
    {1'b0,13'h0000, 1'b0,13'h0000, 1'b0,13'h0000, 13'h0FFE, 13'h1001,13'h0FFE,1'b0}, // R4
    {1'b1,13'h0002, 1'b0,13'h0000, 1'b0,13'h0000, 13'h0000, 13'h1003,13'h0FFE,1'b1}  // R1 R7
  };

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    en_we = 0; dis_we = 0; stat_we = 0;
    en_wdata = '0; dis_wdata = '0; stat_wdata = '0; evt = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 mask", mask_view, 13'h0);
    check("R9 status", status_view, 13'h0);
    check("R9 irq", {12'h0, irq}, 13'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      en_we = TBL[i][81]; en_wdata = TBL[i][80:68];
      dis_we = TBL[i][67]; dis_wdata = TBL[i][66:54];
      stat_we = TBL[i][53]; stat_wdata = TBL[i][52:40];
      evt = TBL[i][39:27];
      tick();
      check($sformatf("R1/R2/R3 mask vec %0d", i), mask_view, TBL[i][26:14]);
      check($sformatf("R4/R5/R6 status vec %0d", i), status_view, TBL[i][13:1]);
      check($sformatf("R7 irq vec %0d", i), {12'h0, irq}, {12'h0, TBL[i][0]});
    end

    // R8: rx trigger from fill threshold
    @(negedge clk); idle(); stat_we = 1; stat_wdata = 13'h1FFF; tick();
    @(negedge clk); idle(); rx_thresh = 6'd4; rx_fill = 7'd3; tick();
    check("R8 below threshold", status_view, 13'h0000);
    @(negedge clk); rx_fill = 7'd4; tick();
    check("R8 reaches threshold", status_view, 13'h0001);
    @(negedge clk); stat_we = 1; stat_wdata = 13'h0001; tick();
    check("R8 clear while held", status_view, 13'h0000);
    @(negedge clk); idle(); rx_fill = 7'd5; tick();
    check("R8 no refire above", status_view, 13'h0000);
    @(negedge clk); rx_fill = 7'd2; tick();
    @(negedge clk); rx_fill = 7'd6; tick();
    check("R8 refire after drop", status_view, 13'h0001);
    @(negedge clk); stat_we = 1; stat_wdata = 13'h0001; rx_thresh = 6'd0; tick();
    @(negedge clk); idle(); rx_fill = 7'd0; tick();
    @(negedge clk); rx_fill = 7'd9; tick();
    check("R8 zero threshold disables", status_view, 13'h0000);
    @(negedge clk); rx_thresh = 6'd63; rx_fill = 7'd62; tick();
    @(negedge clk); rx_fill = 7'd63; tick();
    check("R8 max threshold", status_view, 13'h0001);

    // R9: reset mid-run
    @(negedge clk); en_we = 1; en_wdata = 13'h1FFF; tick();
    @(negedge clk); idle(); rst_n = 1'b0; #1;
    check("R9 mask after reset", mask_view, 13'h0);
    check("R9 status after reset", status_view, 13'h0);
    check("R9 irq after reset", {12'h0, irq}, 13'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule